// File: doc/BRIEF.md
# Mask population count and find-first

This block reduces a vector mask to one scalar. It has two operations. In count mode it returns how many positions are both active and set in the source mask. In find-first mode it returns the lowest position that is both active and set in the source mask. If no such position exists, it returns all ones, which is -1 in two's complement. The caller presents a 32-bit instruction word, the source mask, the v0 mask, the vector length and the vector start index, and asserts a one-cycle start strobe.

The block decodes the instruction and checks it. The result appears together with a one-cycle done pulse exactly two cycles after the strobe. The illegal flag is valid with the same pulse. The pipeline accepts a new strobe on every cycle.

There is no back-pressure. The consumer must take each result in the cycle that done is high, because the block never stalls. Between pulses the result and illegal outputs keep the last value they delivered. Writing the scalar register file, updating the start index and raising the trap are left to the surrounding logic.

Top module: `mask_scalar_reduce`

## Requirements
- R1: In count mode the result is the number of positions i for which the position is active and vs2_mask[i] is 1. This count is zero-extended to XLEN.
- R2: In find-first mode the result is the lowest index i for which the position is active and vs2_mask[i] is 1. This index is zero-extended to XLEN.
- R3: In find-first mode, when no position is both active and set, the result is all ones across XLEN.
- R4: Instruction bit 25 selects the activity mask. When it is 1, every position below vl is active and v0_mask has no effect on the result. When it is 0, a position below vl is active only if its v0_mask bit is 1.
- R5: A position with index greater than or equal to vl is never active. A vl of VLEN or more makes all positions eligible.
- R6: A nonzero vstart makes the operation illegal. An illegal operation delivers illegal = 1 and result = 0.
- R7: The instruction word is recognised only when all of the following hold: bits [6:0] = 1010111, bits [14:12] = 010 and bits [31:26] = 010000. Bits [19:15] must be 10000, which selects count, or 10001, which selects find-first. Any other word is illegal, with result = 0.
- R8: done is high for exactly one cycle, two clock cycles after each start strobe. Strobes on consecutive cycles each produce their own pulse, in order. done is never high without a matching strobe.
- R9: While reset is asserted, done, illegal and result are all 0.
- R10: While done is low, result and illegal keep the values delivered with the previous pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle strobe that launches an operation |
| insn | input | 32 | Instruction word |
| vs2_mask | input | VLEN | Source mask being reduced |
| v0_mask | input | VLEN | Activity mask, used when bit 25 of insn is 0 |
| vl | input | $clog2(VLEN+1) | Vector length |
| vstart | input | $clog2(VLEN) | Vector start index; must be zero |
| done | output | 1 | One-cycle pulse marking a delivered result |
| illegal | output | 1 | Operation rejected; valid with done |
| result | output | XLEN | Scalar result |

## Verification
The pipeline overlaps operations. A new strobe can be captured on the same edge that an older operation completes and raises done. Operations can also be mixed freely in the same stream: count and find-first, legal and illegal. The bench provokes these cases by issuing long runs of strobes on consecutive cycles, with randomly mixed modes, masks, lengths and start indices. It judges each done pulse against the oldest expected entry in a scoreboard, checking the cycle it arrives in, the result value and the illegal flag, so that a lost, duplicated or reordered result is reported.

// File: rtl/mred_pkg.sv
package mred_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_COUNT = 2'd1,
    OP_FIRST = 2'd2
  } mred_op_e;

  typedef struct packed {
    logic [5:0] func_hi;
    logic       unmasked;
    logic [4:0] src_reg;
    logic [4:0] sub_sel;
    logic [2:0] func_lo;
    logic [4:0] dst_reg;
    logic [6:0] major;
  } mred_insn_t;

  localparam logic [6:0] MAJOR_VEC   = 7'b1010111;
  localparam logic [2:0] FUNC_LO_MV  = 3'b010;
  localparam logic [5:0] FUNC_HI_RED = 6'b010000;
  localparam logic [4:0] SEL_COUNT   = 5'b10000;
  localparam logic [4:0] SEL_FIRST   = 5'b10001;

endpackage

// File: rtl/mred_decode.sv
module mred_decode
  import mred_pkg::*;
(
  input  logic [31:0] insn,
  input  logic        vstart_nz,
  output mred_op_e    op,
  output logic        use_v0,
  output logic        illegal
);

  mred_insn_t f;
  logic       frame_ok;

  assign f        = mred_insn_t'(insn);
  assign frame_ok = (f.major == MAJOR_VEC) && (f.func_lo == FUNC_LO_MV) &&
                    (f.func_hi == FUNC_HI_RED);

  always_comb begin
    op = OP_NONE;
    if (frame_ok) begin
      unique case (f.sub_sel)
        SEL_COUNT: op = OP_COUNT;
        SEL_FIRST: op = OP_FIRST;
        default:   op = OP_NONE;
      endcase
    end
  end

  assign use_v0  = ~f.unmasked;
  assign illegal = (op == OP_NONE) || vstart_nz;

endmodule

// File: rtl/mred_active.sv
module mred_active #(
  parameter int VLEN = 128,
  localparam int VLW = $clog2(VLEN + 1)
) (
  input  logic [VLW-1:0]  vl,
  input  logic            use_v0,
  input  logic [VLEN-1:0] v0_mask,
  output logic [VLEN-1:0] active
);

  for (genvar i = 0; i < VLEN; i++) begin : g_pos
    localparam logic [VLW:0] POS = (VLW + 1)'(i);
    assign active[i] = (POS < {1'b0, vl}) && (!use_v0 || v0_mask[i]);
  end

endmodule

// File: rtl/mred_popcnt.sv
module mred_popcnt #(
  parameter int N = 128,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits_in,
  output logic [CW-1:0] total
);

  localparam int NODES = 2 * N - 1;

  logic [CW-1:0] node [NODES];

  always_comb begin
    for (int k = 0; k < N; k++) begin
      node[N - 1 + k] = CW'(bits_in[k]);
    end
    for (int k = N - 2; k >= 0; k--) begin
      node[k] = node[2 * k + 1] + node[2 * k + 2];
    end
  end

  assign total = node[0];

endmodule

// File: rtl/mred_ffs.sv
module mred_ffs #(
  parameter int N = 128,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  bits_in,
  output logic          found,
  output logic [IW-1:0] index
);

  logic [N-1:0] lowest;

  assign lowest = bits_in & (~bits_in + N'(1));
  assign found  = |bits_in;

  always_comb begin
    index = '0;
    for (int i = 0; i < N; i++) begin
      if (lowest[i]) index = index | IW'(i);
    end
  end

endmodule

// File: rtl/mask_scalar_reduce.sv
module mask_scalar_reduce
  import mred_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int XLEN = 64,
  localparam int VLW = $clog2(VLEN + 1),
  localparam int IW  = (VLEN > 1) ? $clog2(VLEN) : 1,
  localparam int CW  = $clog2(VLEN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [31:0]     insn,
  input  logic [VLEN-1:0] vs2_mask,
  input  logic [VLEN-1:0] v0_mask,
  input  logic [VLW-1:0]  vl,
  input  logic [IW-1:0]   vstart,
  output logic            done,
  output logic            illegal,
  output logic [XLEN-1:0] result
);

  // ---------------- stage 1: decode and qualify ----------------
  mred_op_e        dec_op;
  logic            dec_use_v0;
  logic            dec_ill;
  logic [VLEN-1:0] act;

  mred_decode u_dec (
    .insn      (insn),
    .vstart_nz (|vstart),
    .op        (dec_op),
    .use_v0    (dec_use_v0),
    .illegal   (dec_ill)
  );

  mred_active #(.VLEN(VLEN)) u_act (
    .vl      (vl),
    .use_v0  (dec_use_v0),
    .v0_mask (v0_mask),
    .active  (act)
  );

  logic            s1_vld;
  mred_op_e        s1_op;
  logic            s1_ill;
  logic [VLEN-1:0] s1_hits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_op   <= OP_NONE;
      s1_ill  <= 1'b0;
      s1_hits <= '0;
    end else begin
      s1_vld <= start;
      if (start) begin
        s1_op   <= dec_op;
        s1_ill  <= dec_ill;
        s1_hits <= dec_ill ? '0 : (vs2_mask & act);
      end
    end
  end

  // ---------------- stage 2: reduce and deliver ----------------
  logic [CW-1:0]   cnt;
  logic            ff_found;
  logic [IW-1:0]   ff_idx;
  logic [XLEN-1:0] nxt_res;

  mred_popcnt #(.N(VLEN)) u_cnt (
    .bits_in (s1_hits),
    .total   (cnt)
  );

  mred_ffs #(.N(VLEN)) u_ffs (
    .bits_in (s1_hits),
    .found   (ff_found),
    .index   (ff_idx)
  );

  always_comb begin
    if (s1_ill)                nxt_res = '0;
    else if (s1_op == OP_COUNT) nxt_res = XLEN'(cnt);
    else if (ff_found)          nxt_res = XLEN'(ff_idx);
    else                        nxt_res = '1;
  end

  logic            done_q;
  logic            ill_q;
  logic [XLEN-1:0] res_q;
  mred_op_e        s2_op;
  logic [VLEN-1:0] s2_hits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      ill_q   <= 1'b0;
      res_q   <= '0;
      s2_op   <= OP_NONE;
      s2_hits <= '0;
    end else begin
      done_q <= s1_vld;
      if (s1_vld) begin
        ill_q   <= s1_ill;
        res_q   <= nxt_res;
        s2_op   <= s1_op;
        s2_hits <= s1_hits;
      end
    end
  end

  assign done    = done_q;
  assign illegal = ill_q;
  assign result  = res_q;

  // ---------------- assertions ----------------
  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ##2 done);

  assert_no_orphan_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 2));

  assert_vstart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (vstart != '0)) |-> ##2 (done && illegal));

  assert_opcode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (insn[6:0] != MAJOR_VEC)) |-> ##2 (done && illegal));

  assert_illegal_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> (result == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(illegal)));

  assert_count_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal && (s2_op == OP_COUNT)) |-> (result <= XLEN'(VLEN)));

  assert_first_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal && (s2_op == OP_FIRST) && (result != '1)) |->
      ((result < XLEN'(VLEN)) && s2_hits[result[IW-1:0]]));

endmodule

// File: tb/mask_scalar_reduce_bench.sv
module mask_scalar_reduce_bench;

  localparam int VLEN = 128;
  localparam int XLEN = 64;
  localparam int VLW  = $clog2(VLEN + 1);
  localparam int IW   = $clog2(VLEN);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [31:0]     insn = '0;
  logic [VLEN-1:0] vs2_mask = '0;
  logic [VLEN-1:0] v0_mask = '0;
  logic [VLW-1:0]  vl = '0;
  logic [IW-1:0]   vstart = '0;
  logic            done;
  logic            illegal;
  logic [XLEN-1:0] result;

  mask_scalar_reduce #(.VLEN(VLEN), .XLEN(XLEN)) u_mask_scalar_reduce (
    .clk(clk), .rst_n(rst_n), .start(start), .insn(insn),
    .vs2_mask(vs2_mask), .v0_mask(v0_mask), .vl(vl), .vstart(vstart),
    .done(done), .illegal(illegal), .result(result)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  int n_checks = 0;
  int n_fails = 0;
  bit wd_hit = 1'b0;
  bit finished = 1'b0;

  always @(posedge clk) cyc = cyc + 1;

  typedef struct {
    int          due;
    logic [63:0] res;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  exp_t cur;
  logic [XLEN-1:0] last_res = '0;
  logic            last_ill = 1'b0;

  function automatic logic [31:0] mk(input logic [5:0] f6, input logic vm,
                                     input logic [4:0] sel, input logic [2:0] f3,
                                     input logic [6:0] opc);
    return {f6, vm, 5'd3, sel, f3, 5'd9, opc};
  endfunction

  function automatic logic [63:0] model(input logic [31:0] w, input logic [VLEN-1:0] s2,
                                        input logic [VLEN-1:0] m0, input int len,
                                        input int vs, output logic ill);
    int cnt = 0;
    int first = -1;
    bit legal;
    legal = (w[6:0] == 7'b1010111) && (w[14:12] == 3'b010) && (w[31:26] == 6'b010000) &&
            ((w[19:15] == 5'b10000) || (w[19:15] == 5'b10001)) && (vs == 0);
    ill = !legal;
    if (!legal) return 64'd0;
    for (int i = 0; i < VLEN; i++) begin
      if ((i < len) && (w[25] || m0[i]) && s2[i]) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
    if (w[19:15] == 5'b10000) return 64'(cnt);
    return (first < 0) ? '1 : 64'(first);
  endfunction

  task automatic issue(input logic [31:0] w, input logic [VLEN-1:0] s2,
                       input logic [VLEN-1:0] m0, input int len, input int vs,
                       input string tag);
    exp_t e;
    logic ill;
    e.res = model(w, s2, m0, len, vs, ill);
    e.ill = ill;
    e.due = cyc + 2;
    e.tag = tag;
    sbq.push_back(e);
    insn = w; vs2_mask = s2; v0_mask = m0; vl = VLW'(len); vstart = IW'(vs);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done) begin
        n_checks++;
        if (sbq.size() == 0) begin
          n_fails++;
          $display("FAIL R8: done with no pending operation, actual result=%h expected none", result);
        end else begin
          cur = sbq.pop_front();
          if (cur.due != cyc || result !== cur.res || illegal !== cur.ill) begin
            n_fails++;
            $display("FAIL %s: actual cyc=%0d result=%h illegal=%b, expected cyc=%0d result=%h illegal=%b",
                     cur.tag, cyc, result, illegal, cur.due, cur.res, cur.ill);
          end
        end
        last_res = result;
        last_ill = illegal;
      end else begin
        if (sbq.size() > 0 && sbq[0].due <= cyc) begin
          n_checks++;
          n_fails++;
          cur = sbq.pop_front();
          $display("FAIL R8 (%s): no done at cyc=%0d, expected done at cyc=%0d",
                   cur.tag, cyc, cur.due);
        end
        n_checks++;
        if (result !== last_res || illegal !== last_ill) begin
          n_fails++;
          $display("FAIL R10: outputs moved without done, actual %h/%b expected %h/%b",
                   result, illegal, last_res, last_ill);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      wd_hit = 1'b1;
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run hung, actual cyc=%0d expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  localparam logic [5:0] F6 = 6'b010000;
  localparam logic [2:0] F3 = 3'b010;
  localparam logic [6:0] OPC = 7'b1010111;
  localparam logic [4:0] CNT = 5'b10000;
  localparam logic [4:0] FST = 5'b10001;

  initial begin
    logic [VLEN-1:0] ones;
    logic [VLEN-1:0] top;
    ones = '1;
    top = '0; top[VLEN-1] = 1'b1;

    // R9: reset state
    idle(3);
    n_checks++;
    if (done !== 1'b0 || illegal !== 1'b0 || result !== '0) begin
      n_fails++;
      $display("FAIL R9: reset outputs actual %b/%b/%h expected 0/0/0", done, illegal, result);
    end
    rst_n = 1'b1;
    idle(2);

    // R1: full count, and a sparse pattern
    issue(mk(F6, 1'b1, CNT, F3, OPC), ones, '0, VLEN, 0, "R1 full count");
    issue(mk(F6, 1'b1, CNT, F3, OPC), {32{4'b1010}}, '0, VLEN, 0, "R1 alternating count");
    idle(3);
    // R2: single top bit found; lowest of several
    issue(mk(F6, 1'b1, FST, F3, OPC), top, '0, VLEN, 0, "R2 top index");
    issue(mk(F6, 1'b1, FST, F3, OPC), (VLEN'(1) << 40) | (VLEN'(1) << 77), '0, VLEN, 0, "R2 lowest of two");
    // R3: no set bit
    issue(mk(F6, 1'b1, FST, F3, OPC), '0, ones, VLEN, 0, "R3 empty source");
    // R5: vl excludes the only bit; vl zero; vl above VLEN
    issue(mk(F6, 1'b1, FST, F3, OPC), top, '0, VLEN - 1, 0, "R5 bit at vl");
    issue(mk(F6, 1'b1, CNT, F3, OPC), ones, '0, 0, 0, "R5 vl zero count");
    issue(mk(F6, 1'b1, CNT, F3, OPC), ones, '0, 200, 0, "R5 vl above size");
    issue(mk(F6, 1'b1, CNT, F3, OPC), ones, '0, 37, 0, "R5 partial vl");
    idle(3);
    // R4: v0 gating and v0 ignored
    issue(mk(F6, 1'b0, FST, F3, OPC), (VLEN'(1) << 5) | (VLEN'(1) << 9), VLEN'(1) << 9, VLEN, 0, "R4 v0 skips index 5");
    issue(mk(F6, 1'b1, FST, F3, OPC), (VLEN'(1) << 5) | (VLEN'(1) << 9), VLEN'(1) << 9, VLEN, 0, "R4 v0 ignored when unmasked");
    issue(mk(F6, 1'b0, CNT, F3, OPC), ones, {64{2'b01}}, VLEN, 0, "R4 masked count");
    issue(mk(F6, 1'b1, CNT, F3, OPC), ones, '0, VLEN, 0, "R4 unmasked count ignores v0");
    issue(mk(F6, 1'b0, FST, F3, OPC), ones, '0, VLEN, 0, "R4 all inactive gives none");
    idle(3);
    // R6: nonzero vstart
    issue(mk(F6, 1'b1, CNT, F3, OPC), ones, '0, VLEN, 3, "R6 vstart count");
    issue(mk(F6, 1'b1, FST, F3, OPC), ones, '0, VLEN, 1, "R6 vstart first");
    // R7: bad encodings
    issue(mk(F6, 1'b1, 5'b10010, F3, OPC), ones, '0, VLEN, 0, "R7 bad selector");
    issue(mk(6'b010100, 1'b1, CNT, F3, OPC), ones, '0, VLEN, 0, "R7 bad high function");
    issue(mk(F6, 1'b1, CNT, 3'b000, OPC), ones, '0, VLEN, 0, "R7 bad low function");
    issue(mk(F6, 1'b1, FST, F3, 7'b0110011), ones, '0, VLEN, 0, "R7 bad major opcode");
    issue(mk(F6, 1'b1, CNT, F3, OPC), ones, '0, VLEN, 0, "R8 legal after illegal");
    idle(4);

    // R8: long mixed back-to-back stream
    for (int k = 0; k < 80; k++) begin
      logic [VLEN-1:0] a, b;
      logic [4:0] sel;
      int len, vs;
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      if ((k % 5) == 0) a = a & {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
      if ((k % 11) == 0) a = '0;
      sel = ($urandom % 2 == 0) ? CNT : FST;
      if ((k % 17) == 3) sel = 5'b00111;
      len = $urandom % 220;
      vs = ((k % 13) == 7) ? 1 + ($urandom % 100) : 0;
      issue(mk(F6, 1'($urandom % 2), sel, F3, OPC), a, b, len, vs, "R8 mixed stream");
      if ((k % 19) == 18) idle(1 + ($urandom % 3));
    end
    idle(6);

    n_checks++;
    if (sbq.size() != 0) begin
      n_fails++;
      $display("FAIL R8: %0d operations never completed, expected 0", sbq.size());
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule